// File: doc/BRIEF.md
# USB Packet Field Decoder with Status Encoding

This block sits behind a USB receive front end that has already recovered the clock, undone NRZI coding and removed stuffed bits. It accepts the resulting packet bits one at a time, each qualified by a valid strobe. It also takes a pulse marking the end of the sync pattern, a pulse marking end of packet, and a flag from the front end that reports a bit-stuffing violation. A field sequencer walks each packet through its PID, token fields, CRC or payload. The datapath verifies the PID check nibble and the CRC5 or CRC16 residue.

At end of packet the block emits a single 6-bit status code. That code covers every token, data, handshake and error outcome, so a trace or trigger unit needs to watch only one field. The address and endpoint of the most recent good SETUP, IN or OUT token stay latched on the outputs while the data packet that follows is reported. Payload leaves as 16-bit words, and the trailing CRC16 word is withheld.

Operating conditions: `bitValid` pulses are at least four clocks apart, as with a clock of four times the bit rate. `pktEnd` never coincides with `bitValid`. Payloads are a whole number of 16-bit words.

Top module: `usb_pkt_status_decoder`

## Requirements
- R1: `seqState` reads 0000 when idle. It moves to 0001 one cycle after `syncEnd`. After the eighth PID bit it shows 0010 and then 0011, one cycle each. It then shows 0100, 0101 and 0110 for a token (7, 4 and 5 bits), or 0111 for one cycle followed by 1000 for a data packet. It returns to 0000 after the fifth token CRC bit, after `pktEnd`, or after 0011 for any other PID.
- R2: The PID byte arrives LSB first. Its low nibble selects the type: OUT=0001, IN=1001, SOF=0101, SETUP=1101, DATA0=0011, DATA1=1011, ACK=0010, NAK=1010, STALL=1110, PRE=1100. A clean token reports SETUP 000001, IN 000010, OUT 000011 or SOF 000100.
- R3: Handshake and preamble packets report PRE 011000, ACK 011001, NAK 011010 or STALL 011011, and a stuff error does not change these codes.
- R4: If fewer than eight PID bits arrived, or the high nibble is not the complement of the low nibble, the code is 011101. A well-formed PID outside the list in R2 reports 011110.
- R5: DATA0 reports 0X0101 and DATA1 reports 0X0110. X (code bit 4) is 1 exactly when the previous reported packet was a clean SETUP.
- R6: A stuff error seen at any point from `syncEnd` through the `pktEnd` cycle gives SETUP 001001, IN 001010, OUT 001011, SOF 001100, DATA0 001101 or DATA1 001110. This code takes precedence over a CRC failure.
- R7: Token CRC5 uses x^5+x^2+1 with all-ones start, and a valid packet leaves residue 01100. A failing token without a stuff error reports SETUP 010001, IN 010010, OUT 010011 or SOF 010100.
- R8: Data CRC16 uses x^16+x^15+x^2+1 with all-ones start, and a valid packet leaves residue 0x800D. A failing data packet without a stuff error reports 010111.
- R9: After the PID, the token carries 7 address bits and then 4 endpoint bits, each LSB first (SOF uses the same 11 bits as frame number). `addrOut`/`endpOut` load only from a clean SETUP, IN or OUT, in the cycle its status appears, and hold through all other packets.
- R10: Payload bits fill a 16-bit word LSB first. Word n is presented for one cycle on `dataWord` with `dataValid` in the cycle after the 16th bit of word n+1 is sampled. The final word, the CRC16, is never presented.
- R11: `statusValid` is a one-cycle pulse in the cycle after `pktEnd` is sampled. A `pktEnd` with no `syncEnd` since the previous `pktEnd` produces no status.
- R12: During and right after reset, `statusValid`, `dataValid`, `addrOut`, `endpOut` and `seqState` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitValid | input | 1 | Qualifies `bitData` for one cycle |
| bitData | input | 1 | Destuffed packet bit |
| syncEnd | input | 1 | Pulse: sync pattern finished, packet begins |
| pktEnd | input | 1 | Pulse: end of packet detected |
| stuffErr | input | 1 | Bit-stuffing violation seen by the front end |
| statusValid | output | 1 | Status code valid for one cycle |
| statusCode | output | 6 | Per-packet status code |
| addrOut | output | 7 | Latched token address |
| endpOut | output | 4 | Latched token endpoint |
| dataValid | output | 1 | Payload word valid for one cycle |
| dataWord | output | 16 | Payload word |
| seqState | output | 4 | Field sequencer state |

## Verification
Stuff-error tracking and CRC checking both feed the code chosen in the `pktEnd` cycle. The stuff flag can arrive in that same cycle, and the bench raises it together with `pktEnd` on IN and DATA1 packets. On an OUT token the bench combines a stuff error with a corrupted CRC, and the stuff code must win over the CRC code. A second collision is between the address latch and the status report: both happen in one cycle. The scoreboard therefore compares the latched address and endpoint carried with every status item, and a bound property allows the latch to move only alongside a clean token status.

// File: rtl/usbpd_pkg.sv
package usbpd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'b0000,
    ST_PID     = 4'b0001,
    ST_DLY1    = 4'b0010,
    ST_DLY2    = 4'b0011,
    ST_ADDR    = 4'b0100,
    ST_EP      = 4'b0101,
    ST_CRC     = 4'b0110,
    ST_PREDATA = 4'b0111,
    ST_DATA    = 4'b1000
  } seqState_e;

  typedef struct packed {
    logic start;
    logic finish;
    logic pidBit;
    logic pidLast;
    logic tokBit;
    logic addrBit;
    logic epBit;
    logic dataBit;
  } ctrlStrobe_t;

  localparam logic [3:0] P_OUT   = 4'b0001;
  localparam logic [3:0] P_IN    = 4'b1001;
  localparam logic [3:0] P_SOF   = 4'b0101;
  localparam logic [3:0] P_SETUP = 4'b1101;
  localparam logic [3:0] P_DATA0 = 4'b0011;
  localparam logic [3:0] P_DATA1 = 4'b1011;
  localparam logic [3:0] P_ACK   = 4'b0010;
  localparam logic [3:0] P_NAK   = 4'b1010;
  localparam logic [3:0] P_STALL = 4'b1110;
  localparam logic [3:0] P_PRE   = 4'b1100;

  localparam logic [5:0] C_SETUP     = 6'b000001;
  localparam logic [5:0] C_IN        = 6'b000010;
  localparam logic [5:0] C_OUT       = 6'b000011;
  localparam logic [5:0] C_SOF       = 6'b000100;
  localparam logic [5:0] C_PRE       = 6'b011000;
  localparam logic [5:0] C_ACK       = 6'b011001;
  localparam logic [5:0] C_NAK       = 6'b011010;
  localparam logic [5:0] C_STALL     = 6'b011011;
  localparam logic [5:0] C_INVALID   = 6'b011101;
  localparam logic [5:0] C_BAD       = 6'b011110;
  localparam logic [5:0] C_SETUP_STF = 6'b001001;
  localparam logic [5:0] C_IN_STF    = 6'b001010;
  localparam logic [5:0] C_OUT_STF   = 6'b001011;
  localparam logic [5:0] C_SOF_STF   = 6'b001100;
  localparam logic [5:0] C_D0_STF    = 6'b001101;
  localparam logic [5:0] C_D1_STF    = 6'b001110;
  localparam logic [5:0] C_SETUP_CRC = 6'b010001;
  localparam logic [5:0] C_IN_CRC    = 6'b010010;
  localparam logic [5:0] C_OUT_CRC   = 6'b010011;
  localparam logic [5:0] C_SOF_CRC   = 6'b010100;
  localparam logic [5:0] C_DATA_CRC  = 6'b010111;

  localparam int CRC5_W = 5;
  localparam int CRC16_W = 16;
  localparam logic [CRC5_W-1:0]  CRC5_POLY  = 5'h05;
  localparam logic [CRC5_W-1:0]  CRC5_RES   = 5'h0C;
  localparam logic [CRC16_W-1:0] CRC16_POLY = 16'h8005;
  localparam logic [CRC16_W-1:0] CRC16_RES  = 16'h800D;

endpackage

// File: rtl/usbpd_ctrl.sv
module usbpd_ctrl
  import usbpd_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int PID_W  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitValid,
  input  logic        syncEnd,
  input  logic        pktEnd,
  input  logic        isToken,
  input  logic        isData,
  output seqState_e   state,
  output ctrlStrobe_t stb
);

  localparam int MAX_F = (ADDR_W > PID_W) ? ADDR_W : PID_W;
  localparam int CNT_W = $clog2(MAX_F);

  seqState_e  nxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  always_comb begin
    stb    = '0;
    nxt    = state;
    cntNxt = cnt;
    if (pktEnd) begin
      stb.finish = 1'b1;
      nxt        = ST_IDLE;
    end else if (syncEnd) begin
      stb.start = 1'b1;
      nxt       = ST_PID;
      cntNxt    = '0;
    end else begin
      case (state)
        ST_PID: if (bitValid) begin
          stb.pidBit = 1'b1;
          if (cnt == CNT_W'(PID_W - 1)) begin
            stb.pidLast = 1'b1;
            nxt         = ST_DLY1;
            cntNxt      = '0;
          end else cntNxt = cnt + 1'b1;
        end
        ST_DLY1: nxt = ST_DLY2;
        ST_DLY2: nxt = isToken ? ST_ADDR : (isData ? ST_PREDATA : ST_IDLE);
        ST_ADDR: if (bitValid) begin
          stb.tokBit  = 1'b1;
          stb.addrBit = 1'b1;
          if (cnt == CNT_W'(ADDR_W - 1)) begin
            nxt    = ST_EP;
            cntNxt = '0;
          end else cntNxt = cnt + 1'b1;
        end
        ST_EP: if (bitValid) begin
          stb.tokBit = 1'b1;
          stb.epBit  = 1'b1;
          if (cnt == CNT_W'(EP_W - 1)) begin
            nxt    = ST_CRC;
            cntNxt = '0;
          end else cntNxt = cnt + 1'b1;
        end
        ST_CRC: if (bitValid) begin
          stb.tokBit = 1'b1;
          if (cnt == CNT_W'(CRC5_W - 1)) begin
            nxt    = ST_IDLE;
            cntNxt = '0;
          end else cntNxt = cnt + 1'b1;
        end
        ST_PREDATA: begin
          stb.dataBit = bitValid;
          nxt         = ST_DATA;
        end
        ST_DATA: stb.dataBit = bitValid;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cntNxt;
    end
  end

endmodule

// File: rtl/usbpd_datapath.sv
module usbpd_datapath
  import usbpd_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int WORD_W = 16,
  parameter int PID_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitData,
  input  logic              stuffErr,
  input  ctrlStrobe_t       stb,
  output logic              isToken,
  output logic              isData,
  output logic              statusValid,
  output logic [5:0]        statusCode,
  output logic [ADDR_W-1:0] addrOut,
  output logic [EP_W-1:0]   endpOut,
  output logic              dataValid,
  output logic [WORD_W-1:0] dataWord
);

  localparam int WC_W = $clog2(WORD_W);
  localparam int NIB  = PID_W / 2;

  logic [PID_W-1:0]   pidReg;
  logic               pidComplete, stuffSeen, inPkt, lastSetup;
  logic [ADDR_W-1:0]  addrSh;
  logic [EP_W-1:0]    epSh;
  logic [CRC5_W-1:0]  crc5;
  logic [CRC16_W-1:0] crc16;
  logic [WORD_W-1:0]  curWord, pendWord, nextWord;
  logic               pendFull;
  logic [WC_W-1:0]    wordCnt;
  logic [NIB-1:0]     nib;
  logic               pidOk, stuffNow, crc5Ok, crc16Ok;
  logic [5:0]         code;

  assign nib      = pidReg[NIB-1:0];
  assign pidOk    = pidComplete && (pidReg[PID_W-1:NIB] == ~nib);
  assign isToken  = pidOk && (nib == P_OUT || nib == P_IN || nib == P_SOF || nib == P_SETUP);
  assign isData   = pidOk && (nib == P_DATA0 || nib == P_DATA1);
  assign stuffNow = stuffSeen | stuffErr;
  assign crc5Ok   = (crc5 == CRC5_RES);
  assign crc16Ok  = (crc16 == CRC16_RES);
  assign nextWord = {bitData, curWord[WORD_W-1:1]};

  always_comb begin
    code = C_INVALID;
    if (pidOk) begin
      case (nib)
        P_SETUP: code = stuffNow ? C_SETUP_STF : (!crc5Ok ? C_SETUP_CRC : C_SETUP);
        P_IN:    code = stuffNow ? C_IN_STF    : (!crc5Ok ? C_IN_CRC    : C_IN);
        P_OUT:   code = stuffNow ? C_OUT_STF   : (!crc5Ok ? C_OUT_CRC   : C_OUT);
        P_SOF:   code = stuffNow ? C_SOF_STF   : (!crc5Ok ? C_SOF_CRC   : C_SOF);
        P_DATA0: code = stuffNow ? C_D0_STF : (!crc16Ok ? C_DATA_CRC : {1'b0, lastSetup, 4'b0101});
        P_DATA1: code = stuffNow ? C_D1_STF : (!crc16Ok ? C_DATA_CRC : {1'b0, lastSetup, 4'b0110});
        P_ACK:   code = C_ACK;
        P_NAK:   code = C_NAK;
        P_STALL: code = C_STALL;
        P_PRE:   code = C_PRE;
        default: code = C_BAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pidReg      <= '0;
      pidComplete <= 1'b0;
      stuffSeen   <= 1'b0;
      inPkt       <= 1'b0;
      lastSetup   <= 1'b0;
      addrSh      <= '0;
      epSh        <= '0;
      crc5        <= '1;
      crc16       <= '1;
      curWord     <= '0;
      pendWord    <= '0;
      pendFull    <= 1'b0;
      wordCnt     <= '0;
      statusValid <= 1'b0;
      statusCode  <= '0;
      addrOut     <= '0;
      endpOut     <= '0;
      dataValid   <= 1'b0;
      dataWord    <= '0;
    end else begin
      statusValid <= 1'b0;
      dataValid   <= 1'b0;
      if (stb.start) begin
        pidReg      <= '0;
        pidComplete <= 1'b0;
        stuffSeen   <= 1'b0;
        inPkt       <= 1'b1;
        crc5        <= '1;
        crc16       <= '1;
        pendFull    <= 1'b0;
        wordCnt     <= '0;
      end else begin
        stuffSeen <= stuffNow;
      end
      if (stb.pidBit)  pidReg <= {bitData, pidReg[PID_W-1:1]};
      if (stb.pidLast) pidComplete <= 1'b1;
      if (stb.addrBit) addrSh <= {bitData, addrSh[ADDR_W-1:1]};
      if (stb.epBit)   epSh   <= {bitData, epSh[EP_W-1:1]};
      if (stb.tokBit)
        crc5 <= {crc5[CRC5_W-2:0], 1'b0} ^ ((bitData ^ crc5[CRC5_W-1]) ? CRC5_POLY : '0);
      if (stb.dataBit) begin
        crc16   <= {crc16[CRC16_W-2:0], 1'b0} ^ ((bitData ^ crc16[CRC16_W-1]) ? CRC16_POLY : '0);
        curWord <= nextWord;
        wordCnt <= wordCnt + 1'b1;
        if (wordCnt == WC_W'(WORD_W - 1)) begin
          pendWord <= nextWord;
          pendFull <= 1'b1;
          if (pendFull) begin
            dataValid <= 1'b1;
            dataWord  <= pendWord;
          end
        end
      end
      if (stb.finish && inPkt) begin
        inPkt       <= 1'b0;
        statusValid <= 1'b1;
        statusCode  <= code;
        lastSetup   <= (code == C_SETUP);
        if (code == C_SETUP || code == C_IN || code == C_OUT) begin
          addrOut <= addrSh;
          endpOut <= epSh;
        end
      end
    end
  end

endmodule

// File: rtl/usb_pkt_status_decoder.sv
module usb_pkt_status_decoder
  import usbpd_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              bitData,
  input  logic              syncEnd,
  input  logic              pktEnd,
  input  logic              stuffErr,
  output logic              statusValid,
  output logic [5:0]        statusCode,
  output logic [ADDR_W-1:0] addrOut,
  output logic [EP_W-1:0]   endpOut,
  output logic              dataValid,
  output logic [WORD_W-1:0] dataWord,
  output logic [3:0]        seqState
);

  seqState_e   stateW;
  ctrlStrobe_t stbW;
  logic        isTokenW, isDataW;

  usbpd_ctrl #(.ADDR_W(ADDR_W), .EP_W(EP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .syncEnd(syncEnd), .pktEnd(pktEnd),
    .isToken(isTokenW), .isData(isDataW), .state(stateW), .stb(stbW)
  );

  usbpd_datapath #(.ADDR_W(ADDR_W), .EP_W(EP_W), .WORD_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .bitData(bitData), .stuffErr(stuffErr), .stb(stbW),
    .isToken(isTokenW), .isData(isDataW), .statusValid(statusValid),
    .statusCode(statusCode), .addrOut(addrOut), .endpOut(endpOut),
    .dataValid(dataValid), .dataWord(dataWord)
  );

  assign seqState = stateW;

endmodule

// File: rtl/usbpd_checker.sv
module usbpd_checker #(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              syncEnd,
  input logic              pktEnd,
  input logic              statusValid,
  input logic [5:0]        statusCode,
  input logic [ADDR_W-1:0] addrOut,
  input logic [EP_W-1:0]   endpOut,
  input logic              dataValid,
  input logic [3:0]        seqState
);

  a_r11_single_status: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> !statusValid);

  a_r11_status_after_end: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> $past(pktEnd));

  a_r1_sync_to_pid: assert property (@(posedge clk) disable iff (!rstN)
    (syncEnd && !pktEnd) |=> (seqState == 4'b0001));

  a_r1_delay_order: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 4'b0010 && !pktEnd && !syncEnd) |=> (seqState == 4'b0011));

  a_r9_latch_on_token: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(addrOut) || !$stable(endpOut)) |->
      (statusValid && (statusCode == 6'b000001 || statusCode == 6'b000010 || statusCode == 6'b000011)));

  a_r10_word_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

endmodule

bind usb_pkt_status_decoder usbpd_checker #(.ADDR_W(ADDR_W), .EP_W(EP_W)) uChk (
  .clk(clk), .rstN(rstN), .syncEnd(syncEnd), .pktEnd(pktEnd),
  .statusValid(statusValid), .statusCode(statusCode), .addrOut(addrOut),
  .endpOut(endpOut), .dataValid(dataValid), .seqState(seqState)
);

// File: tb/tb_usb_pkt_status_decoder.sv
module tb_usb_pkt_status_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0, bitData = 1'b0, syncEnd = 1'b0, pktEnd = 1'b0, stuffErr = 1'b0;
  logic statusValid, dataValid;
  logic [5:0] statusCode;
  logic [6:0] addrOut;
  logic [3:0] endpOut, seqState;
  logic [15:0] dataWord;

  int checks = 0;
  int errors = 0;
  logic [16:0] expStatQ[$];
  logic [15:0] expDataQ[$];
  logic [6:0] expAddr = '0;
  logic [3:0] expEp = '0;
  bit lastSetupExp = 1'b0;

  always #10 clk = ~clk;

  usb_pkt_status_decoder dut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitData(bitData), .syncEnd(syncEnd),
    .pktEnd(pktEnd), .stuffErr(stuffErr), .statusValid(statusValid), .statusCode(statusCode),
    .addrOut(addrOut), .endpOut(endpOut), .dataValid(dataValid), .dataWord(dataWord),
    .seqState(seqState)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && statusValid) begin
      if (expStatQ.size() == 0) check(1'b0, "R11 unexpected status", {26'd0, statusCode}, 32'h0);
      else begin
        logic [16:0] e;
        e = expStatQ.pop_front();
        check({statusCode, addrOut, endpOut} == e, "R2-R9 status/latch", {15'd0, statusCode, addrOut, endpOut}, {15'd0, e});
      end
    end
    if (rstN && dataValid) begin
      if (expDataQ.size() == 0) check(1'b0, "R10 unexpected word", {16'd0, dataWord}, 32'h0);
      else begin
        logic [15:0] w;
        w = expDataQ.pop_front();
        check(dataWord == w, "R10 payload word", {16'd0, dataWord}, {16'd0, w});
      end
    end
  end

  function automatic logic [5:0] expCode(input logic [7:0] pid, input bit full, input bit stf, input bit crcBad, input bit lastS);
    logic [3:0] n;
    n = pid[3:0];
    if (!full || pid[7:4] != ~n) return 6'b011101;
    case (n)
      4'b1101: return stf ? 6'b001001 : crcBad ? 6'b010001 : 6'b000001;
      4'b1001: return stf ? 6'b001010 : crcBad ? 6'b010010 : 6'b000010;
      4'b0001: return stf ? 6'b001011 : crcBad ? 6'b010011 : 6'b000011;
      4'b0101: return stf ? 6'b001100 : crcBad ? 6'b010100 : 6'b000100;
      4'b0011: return stf ? 6'b001101 : crcBad ? 6'b010111 : {1'b0, lastS, 4'b0101};
      4'b1011: return stf ? 6'b001110 : crcBad ? 6'b010111 : {1'b0, lastS, 4'b0110};
      4'b0010: return 6'b011001;
      4'b1010: return 6'b011010;
      4'b1110: return 6'b011011;
      4'b1100: return 6'b011000;
      default: return 6'b011110;
    endcase
  endfunction

  task automatic pushStatus(input logic [5:0] c, input logic [10:0] fld);
    if (c == 6'b000001 || c == 6'b000010 || c == 6'b000011) begin
      expAddr = fld[6:0];
      expEp = fld[10:7];
    end
    lastSetupExp = (c == 6'b000001);
    expStatQ.push_back({c, expAddr, expEp});
  endtask

  task automatic sendBit(input logic b, input bit stf);
    bitValid = 1'b1; bitData = b; stuffErr = stf;
    @(negedge clk);
    bitValid = 1'b0; stuffErr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseSync();
    syncEnd = 1'b1;
    @(negedge clk);
    syncEnd = 1'b0;
  endtask

  task automatic endPkt(input bit stf);
    pktEnd = 1'b1; stuffErr = stf;
    @(negedge clk);
    pktEnd = 1'b0; stuffErr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendPid(input logic [7:0] pb, input bit chk, input bit isDat);
    for (int i = 0; i < 7; i++) sendBit(pb[i], 1'b0);
    bitValid = 1'b1; bitData = pb[7];
    @(negedge clk);
    bitValid = 1'b0;
    if (chk) check(seqState == 4'b0010, "R1 DELAY_1", {28'd0, seqState}, 32'h2);
    @(negedge clk);
    if (chk) check(seqState == 4'b0011, "R1 DELAY_2", {28'd0, seqState}, 32'h3);
    @(negedge clk);
    if (chk) check(seqState == (isDat ? 4'b0111 : 4'b0100), "R1 branch", {28'd0, seqState}, isDat ? 32'h7 : 32'h4);
    @(negedge clk);
    if (chk && isDat) check(seqState == 4'b1000, "R1 DATA", {28'd0, seqState}, 32'h8);
  endtask

  task automatic sendToken(input logic [3:0] n, input logic [10:0] fld, input bit crcBad,
                           input bit stfMid, input bit stfEnd, input bit chk);
    logic [4:0] c;
    pushStatus(expCode({~n, n}, 1'b1, stfMid | stfEnd, crcBad, lastSetupExp), fld);
    pulseSync();
    if (chk) check(seqState == 4'b0001, "R1 PID state", {28'd0, seqState}, 32'h1);
    sendPid({~n, n}, chk, 1'b0);
    c = 5'h1F;
    for (int i = 0; i < 11; i++) begin
      c = {c[3:0], 1'b0} ^ ((fld[i] ^ c[4]) ? 5'h05 : 5'h00);
      sendBit(fld[i], stfMid && i == 2);
      if (chk && i == 6) check(seqState == 4'b0101, "R1 EP state", {28'd0, seqState}, 32'h5);
    end
    if (chk) check(seqState == 4'b0110, "R1 CRC state", {28'd0, seqState}, 32'h6);
    for (int i = 4; i >= 0; i--) sendBit(~c[i] ^ (crcBad && i == 4), 1'b0);
    if (chk) check(seqState == 4'b0000, "R1 back to IDLE", {28'd0, seqState}, 32'h0);
    endPkt(stfEnd);
  endtask

  task automatic sendData(input logic [3:0] n, input int words, input logic [15:0] seed,
                          input bit crcBad, input bit stfMid, input bit stfEnd, input bit chk);
    logic [15:0] c, w;
    pushStatus(expCode({~n, n}, 1'b1, stfMid | stfEnd, crcBad, lastSetupExp), 11'd0);
    pulseSync();
    sendPid({~n, n}, chk, 1'b1);
    c = 16'hFFFF;
    for (int k = 0; k < words; k++) begin
      w = seed ^ (16'h1357 * 16'(k + 1));
      expDataQ.push_back(w);
      for (int i = 0; i < 16; i++) begin
        c = {c[14:0], 1'b0} ^ ((w[i] ^ c[15]) ? 16'h8005 : 16'h0);
        sendBit(w[i], stfMid && k == 0 && i == 5);
      end
    end
    for (int i = 15; i >= 0; i--) sendBit(~c[i] ^ (crcBad && i == 15), 1'b0);
    endPkt(stfEnd);
  endtask

  task automatic sendRaw(input logic [7:0] pb, input int nbits, input bit stf);
    pushStatus(expCode(pb, nbits == 8, stf, 1'b0, lastSetupExp), 11'd0);
    pulseSync();
    for (int i = 0; i < nbits; i++) sendBit(pb[i], stf && i == 1);
    repeat (4) @(negedge clk);
    endPkt(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(statusValid == 1'b0, "R12 statusValid in reset", {31'd0, statusValid}, 32'd0);
    check(dataValid == 1'b0, "R12 dataValid in reset", {31'd0, dataValid}, 32'd0);
    check(addrOut == 7'd0, "R12 addrOut in reset", {25'd0, addrOut}, 32'd0);
    check(endpOut == 4'd0, "R12 endpOut in reset", {28'd0, endpOut}, 32'd0);
    check(seqState == 4'd0, "R12 seqState in reset", {28'd0, seqState}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(statusValid == 1'b0 && seqState == 4'd0, "R12 after reset", {27'd0, statusValid, seqState}, 32'd0);

    // R1 R2 R9: IN token with state walk
    sendToken(4'b1001, {4'h5, 7'h2A}, 1'b0, 1'b0, 1'b0, 1'b1);
    // R5: SETUP then DATA0 carries X=1, DATA1 after data carries X=0
    sendToken(4'b1101, {4'h3, 7'h15}, 1'b0, 1'b0, 1'b0, 1'b0);
    sendData(4'b0011, 2, 16'hA5C3, 1'b0, 1'b0, 1'b0, 1'b0);
    sendData(4'b1011, 1, 16'h0F0F, 1'b0, 1'b0, 1'b0, 1'b0);
    // R1 R10: OUT then DATA0 with state walk, three words
    sendToken(4'b0001, {4'hF, 7'h7F}, 1'b0, 1'b0, 1'b0, 1'b0);
    sendData(4'b0011, 3, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1);
    // R2 R9: SOF does not move the latch
    sendToken(4'b0101, 11'h5A3, 1'b0, 1'b0, 1'b0, 1'b0);
    // R3: handshakes, stuff error ignored on ACK
    sendRaw(8'hD2, 8, 1'b0);
    sendRaw(8'h5A, 8, 1'b0);
    sendRaw(8'h1E, 8, 1'b0);
    sendRaw(8'h3C, 8, 1'b0);
    sendRaw(8'hD2, 8, 1'b1);
    // R4: invalid, bad, truncated PID
    sendRaw(8'h11, 8, 1'b0);
    sendRaw(8'hB4, 8, 1'b0);
    sendRaw(8'hE1, 3, 1'b0);
    // R11: end of packet with no sync gives no status
    endPkt(1'b0);
    check(statusValid == 1'b0, "R11 no status without sync", {31'd0, statusValid}, 32'd0);
    // R7: token CRC failures leave latch alone
    sendToken(4'b1101, {4'h1, 7'h01}, 1'b1, 1'b0, 1'b0, 1'b0);
    sendToken(4'b1001, {4'h2, 7'h02}, 1'b1, 1'b0, 1'b0, 1'b0);
    sendToken(4'b0001, {4'h3, 7'h03}, 1'b1, 1'b0, 1'b0, 1'b0);
    sendToken(4'b0101, 11'h7FF, 1'b1, 1'b0, 1'b0, 1'b0);
    // R8: data CRC failure, words still presented
    sendData(4'b1011, 2, 16'hBEEF, 1'b1, 1'b0, 1'b0, 1'b0);
    // R6: stuff codes, incl. flag on the end cycle and stuff over CRC
    sendToken(4'b1101, {4'h4, 7'h44}, 1'b0, 1'b1, 1'b0, 1'b0);
    sendToken(4'b1001, {4'h6, 7'h66}, 1'b0, 1'b0, 1'b1, 1'b0);
    sendToken(4'b0001, {4'h7, 7'h77}, 1'b1, 1'b1, 1'b0, 1'b0);
    sendToken(4'b0101, 11'h123, 1'b0, 1'b1, 1'b0, 1'b0);
    sendData(4'b0011, 1, 16'h5555, 1'b0, 1'b1, 1'b0, 1'b0);
    sendData(4'b1011, 1, 16'hAAAA, 1'b0, 1'b0, 1'b1, 1'b0);
    // R5: SETUP then DATA1 with X=1
    sendToken(4'b1101, {4'h9, 7'h33}, 1'b0, 1'b0, 1'b0, 1'b0);
    sendData(4'b1011, 1, 16'h00FF, 1'b0, 1'b0, 1'b0, 1'b0);

    repeat (10) @(negedge clk);
    check(expStatQ.size() == 0, "R11 all statuses seen", expStatQ.size(), 32'd0);
    check(expDataQ.size() == 0, "R10 all words seen", expDataQ.size(), 32'd0);
    summary();
    $finish;
  end

endmodule